// File: doc/BRIEF.md
# Dimension-Order Mesh Route Stage

This block is the route-computation pipeline stage of a two-dimensional mesh router. When a head flit arrives, it looks at the destination address and picks one output port. The X dimension is resolved first and the Y dimension second. When both coordinates match the router's own position, the flit leaves through one of several local ejection ports. There can be more than one such port because several endpoints may share one router, and the low bits of the destination choose among them.

Alongside the port, the stage produces an inclusive range of virtual channels that the packet may be allocated on the next hop. The range is taken from a per-flit class input. The result is registered, so it can be written into the per-VC state of the input unit one cycle later. The router's own coordinates are parameters.

The destination word is laid out as {y, x, local_index}:
- local_index occupies the low LW bits.
- x occupies the next XW bits.
- y occupies the top YW bits.

Top module: `mesh_route_stage`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` and `in_head` both high. After reset, `out_valid`, `out_port`, `out_vc_lo` and `out_vc_hi` are all zero.
- R2: When the destination x is above MY_X, the port is East (bit 0). When it is below MY_X, the port is West (bit 1). This holds whatever the destination y is.
- R3: When the destination x equals MY_X, the port depends on y. A destination y above MY_Y selects North (bit 2). A destination y below MY_Y selects South (bit 3).
- R4: When both coordinates match, the port is local port bit 4+i, where i is the local_index field. An index of CONC or more selects the last local port, bit 4+CONC-1.
- R5: For class c, first clamp c to VC_CLASSES-1. Then `out_vc_lo` = c*(NUM_VC/VC_CLASSES) and `out_vc_hi` = `out_vc_lo` + NUM_VC/VC_CLASSES - 1. With a single class, the range is 0 to NUM_VC-1.
- R6: A cycle without a valid head flit has no effect on the stored result. Body flits and idle cycles leave `out_port`, `out_vc_lo` and `out_vc_hi` unchanged in the next cycle, and `out_valid` goes low.
- R7: Whenever `out_valid` is high, `out_port` has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A flit is present this cycle |
| in_head | input | 1 | The present flit is a head flit |
| in_dest | input | YW+XW+LW | Destination {y, x, local_index} |
| in_vclass | input | CLW | VC class of the packet |
| out_valid | output | 1 | Registered routing result is new |
| out_port | output | 4+CONC | One-hot port: E, W, N, S, Local0.. |
| out_vc_lo | output | VCW | Lowest permitted VC (inclusive) |
| out_vc_hi | output | VCW | Highest permitted VC (inclusive) |

## Verification
The checker holds the following on every cycle:
- the one-cycle valid timing and one-hot port (R1, R7);
- that an off-column destination always leaves horizontally (R2);
- that a matched column never goes East or West (R3);
- that the stored result holds across body and idle cycles (R6);
- that the VC range is ordered.

The following are shown only by the bench's scenarios, which compare against independently computed expected values:
- the exact port chosen among the four directions and the local ports;
- the clamping of out-of-range local indices and classes (R4);
- the exact VC bounds (R5).

// File: rtl/mesh_route_stage.sv
module mesh_route_stage #(
  parameter int MESH_X     = 4,
  parameter int MESH_Y     = 4,
  parameter int CONC       = 2,
  parameter int NUM_VC     = 4,
  parameter int VC_CLASSES = 1,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1,
  localparam int XW     = (MESH_X > 1) ? $clog2(MESH_X) : 1,
  localparam int YW     = (MESH_Y > 1) ? $clog2(MESH_Y) : 1,
  localparam int LW     = (CONC > 1) ? $clog2(CONC) : 1,
  localparam int DW     = YW + XW + LW,
  localparam int NPORT  = 4 + CONC,
  localparam int VCW    = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CLW    = (VC_CLASSES > 1) ? $clog2(VC_CLASSES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_head,
  input  logic [DW-1:0]    in_dest,
  input  logic [CLW-1:0]   in_vclass,
  output logic             out_valid,
  output logic [NPORT-1:0] out_port,
  output logic [VCW-1:0]   out_vc_lo,
  output logic [VCW-1:0]   out_vc_hi
);

  localparam int PER = NUM_VC / VC_CLASSES;
  localparam logic [XW-1:0] MYX = XW'(MY_X);
  localparam logic [YW-1:0] MYY = YW'(MY_Y);

  wire [LW-1:0] dl = in_dest[0 +: LW];
  wire [XW-1:0] dx = in_dest[LW +: XW];
  wire [YW-1:0] dy = in_dest[LW+XW +: YW];
  wire          take = in_valid & in_head;

  int lsel;
  int csel;
  logic [NPORT-1:0] port_c;
  logic [VCW-1:0]   lo_c, hi_c;

  assign lsel = (int'(dl) >= CONC) ? CONC - 1 : int'(dl);
  assign csel = (int'(in_vclass) >= VC_CLASSES) ? VC_CLASSES - 1 : int'(in_vclass);
  assign lo_c = VCW'(csel * PER);
  assign hi_c = VCW'(csel * PER + PER - 1);

  always_comb begin
    port_c = '0;
    if (dx > MYX)      port_c[0] = 1'b1;
    else if (dx < MYX) port_c[1] = 1'b1;
    else if (dy > MYY) port_c[2] = 1'b1;
    else if (dy < MYY) port_c[3] = 1'b1;
    else               port_c[4 + lsel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_port  <= '0;
      out_vc_lo <= '0;
      out_vc_hi <= '0;
    end else begin
      out_valid <= take;
      if (take) begin
        out_port  <= port_c;
        out_vc_lo <= lo_c;
        out_vc_hi <= hi_c;
      end
    end
  end

endmodule

// File: rtl/mesh_route_stage_chk.sv
module mesh_route_stage_chk #(
  parameter int MY_X  = 1,
  parameter int XW    = 2,
  parameter int YW    = 2,
  parameter int LW    = 1,
  parameter int DW    = 5,
  parameter int NPORT = 6,
  parameter int VCW   = 2,
  parameter int CLW   = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_head,
  input logic [DW-1:0]    in_dest,
  input logic [CLW-1:0]   in_vclass,
  input logic             out_valid,
  input logic [NPORT-1:0] out_port,
  input logic [VCW-1:0]   out_vc_lo,
  input logic [VCW-1:0]   out_vc_hi
);
  localparam logic [XW-1:0] MYX = XW'(MY_X);
  wire [XW-1:0] cx = in_dest[LW +: XW];

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head) |=> out_valid);

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_head) |=> (!out_valid && $stable(out_port) && $stable(out_vc_lo) && $stable(out_vc_hi)));

  // R7
  port_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_port) == 1);

  // R2
  x_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head && cx != MYX) |=> (out_port[0] || out_port[1]));

  // R3
  x_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_head && cx == MYX) |=> (!out_port[0] && !out_port[1]));

  // R5
  vc_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_vc_lo <= out_vc_hi);
endmodule

bind mesh_route_stage mesh_route_stage_chk #(
  .MY_X(MY_X), .XW(XW), .YW(YW), .LW(LW), .DW(DW),
  .NPORT(NPORT), .VCW(VCW), .CLW(CLW)
) chk_i (.*);

// File: tb/mesh_route_stage_tb_top.sv
`timescale 1ns/1ps
module mesh_route_stage_tb_top;
  localparam int MESH_X = 4, MESH_Y = 4, CONC = 3, NUM_VC = 6, VC_CLASSES = 3;
  localparam int MY_X = 1, MY_Y = 2;
  localparam int XW = 2, YW = 2, LW = 2, DW = 6, NPORT = 7, VCW = 3, CLW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_head = 1'b0;
  logic [DW-1:0] in_dest = '0;
  logic [CLW-1:0] in_vclass = '0;
  logic out_valid;
  logic [NPORT-1:0] out_port;
  logic [VCW-1:0] out_vc_lo, out_vc_hi;

  int checks = 0, fails = 0;
  logic [NPORT-1:0] e_port = '0;
  int e_lo = 0, e_hi = 0;

  always #2 clk = ~clk;

  mesh_route_stage #(.MESH_X(MESH_X), .MESH_Y(MESH_Y), .CONC(CONC), .NUM_VC(NUM_VC),
    .VC_CLASSES(VC_CLASSES), .MY_X(MY_X), .MY_Y(MY_Y)) dut_i (.*);

  function automatic logic [NPORT-1:0] exp_port(int x, int y, int l);
    logic [NPORT-1:0] p = '0;
    if (x > MY_X) p[0] = 1'b1;
    else if (x < MY_X) p[1] = 1'b1;
    else if (y > MY_Y) p[2] = 1'b1;
    else if (y < MY_Y) p[3] = 1'b1;
    else p[4 + ((l >= CONC) ? CONC - 1 : l)] = 1'b1;
    return p;
  endfunction

  function automatic string port_tag(int x, int y);
    if (x != MY_X) return "R2";
    if (y != MY_Y) return "R3";
    return "R4";
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(bit v, bit h, int x, int y, int l, int c);
    int cc;
    @(negedge clk);
    in_valid = v; in_head = h;
    in_dest = {YW'(y), XW'(x), LW'(l)};
    in_vclass = CLW'(c);
    if (v && h) begin
      cc = (c >= VC_CLASSES) ? VC_CLASSES - 1 : c;
      e_port = exp_port(x, y, l);
      e_lo = cc * (NUM_VC / VC_CLASSES);
      e_hi = e_lo + NUM_VC / VC_CLASSES - 1;
    end
    @(negedge clk);
    if (v && h) begin
      chk("R1 valid", int'(out_valid), 1);
      chk({port_tag(x, y), " port"}, int'(out_port), int'(e_port));
      chk("R5 vc_lo", int'(out_vc_lo), e_lo);
      chk("R5 vc_hi", int'(out_vc_hi), e_hi);
    end else begin
      chk("R6 valid", int'(out_valid), 0);
      chk("R6 port hold", int'(out_port), int'(e_port));
      chk("R6 vc_lo hold", int'(out_vc_lo), e_lo);
      chk("R6 vc_hi hold", int'(out_vc_hi), e_hi);
    end
    if (out_valid) chk("R7 onehot", $countones(out_port), 1);
    in_valid = 1'b0; in_head = 1'b0;
  endtask

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset port", int'(out_port), 0);
    chk("R1 reset vc", int'(out_vc_lo) + int'(out_vc_hi), 0);
    rst_n = 1'b1;
    apply(1, 1, 3, 0, 0, 0);   // R2 east despite y below
    apply(1, 1, 0, 3, 1, 1);   // R2 west despite y above
    apply(1, 1, 1, 3, 0, 2);   // R3 north
    apply(1, 1, 1, 0, 2, 0);   // R3 south
    apply(1, 1, 1, 2, 0, 1);   // R4 local0
    apply(1, 1, 1, 2, 2, 2);   // R4 local2
    apply(1, 1, 1, 2, 3, 3);   // R4 index clamp, R5 class clamp
    apply(1, 0, 3, 3, 1, 0);   // R6 body flit
    apply(0, 1, 0, 0, 0, 1);   // R6 idle
    apply(1, 1, 2, 2, 1, 1);   // R2 east same row
    for (int i = 0; i < 400; i++)
      apply(($urandom % 5) != 0, ($urandom % 4) != 0, $urandom % MESH_X,
            $urandom % MESH_Y, $urandom % 4, $urandom % 4);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule